// File: doc/BRIEF.md
# Rotating-Priority Stream Merger

This block merges several AXI-Stream sources onto one AXI-Stream output. Each source gives data, valid and last on packed arrays and gets its own ready back. A rotating pointer sets which source is checked first. The first source found valid in that order is routed to the output in the same cycle, so no cycle is lost before the first beat.

A compile-time mode parameter selects the grant policy. In packet mode the winner keeps the output until a beat with last set is accepted, so packets from different sources never mix. In beat mode the grant is released after every accepted beat, which shares the output finely between sources. In both modes a source that has been put on the output stays there while the sink stalls. A waiting beat therefore never moves to a different source.

Reset is synchronous and active high. It returns the pointer to source 0 and clears any held grant.

Top module: `strm_rr_merge`

## Requirements
- R1: With no grant held, the candidate sources are visited in the order ptr, ptr+1, … wrapping past SRC_COUNT-1 to 0. The first valid one wins. For example, with 4 sources and ptr=2 the order is 2,3,0,1.
- R2: With no grant held, `out_valid` rises in the same cycle that any source is valid. `out_data` and `out_last` carry the winner's beat in that cycle.
- R3: If a source is on the output and `out_ready` is low, that same source stays on the output in the following cycles until its beat is accepted. This holds even when a source earlier in the scan order becomes valid.
- R4: In packet mode (MODE = ARB_PACKET, encoding 1), once a beat with last low is accepted, only that source is served until a beat with last high is accepted. Packets never interleave.
- R5: In packet mode, a single-beat packet accepted with no grant held leaves no grant behind. The following cycle is arbitrated afresh.
- R6: When a unit completes, the pointer becomes the winner index plus one, with SRC_COUNT-1 wrapping to 0. A unit is a last beat in packet mode, or any accepted beat in beat mode.
- R7: At most one source sees ready high. That source is the one on the output, and its ready equals `out_ready`.
- R8: In beat mode (MODE = ARB_BEAT, encoding 0), every accepted beat completes a unit. The next beat is arbitrated from the new pointer, whatever the last flag of the accepted beat.
- R9: When no source is served, `out_valid`, `out_last` and `out_data` are all zero.
- R10: After reset the pointer is 0 and no grant is held. With all sources valid, source 0 wins first.
- R11: Beats from each source leave in the order they were offered. None are dropped or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_data | input | SRC_COUNT x DATA_W | Per-source data, source 0 in the low slice |
| src_valid | input | SRC_COUNT | Per-source valid |
| src_last | input | SRC_COUNT | Per-source end-of-packet flag |
| src_ready | output | SRC_COUNT | Per-source ready |
| out_data | output | DATA_W | Merged data |
| out_valid | output | 1 | Merged valid |
| out_last | output | 1 | Merged end-of-packet flag |
| out_ready | input | 1 | Downstream ready |

## Verification
Every output (valid, data, last and each ready) depends combinationally on the current inputs and on state registered at the previous edge. The reference model therefore predicts the values for the same cycle the stimulus is applied. The bench drives inputs just after a rising edge and compares all outputs at the following falling edge. It updates the model's pointer and held grant from the handshake seen at that falling edge, so the model changes at the same rising edge as the design's registers. Packet mode and beat mode run side by side on separate instances, each under random stalls on both the source side and the sink side.

// File: rtl/stream_arb_pkg.sv
package stream_arb_pkg;

    typedef enum logic {
        ARB_BEAT   = 1'b0,
        ARB_PACKET = 1'b1
    } arb_mode_e;

    // index after cur, wrapping n-1 back to 0
    function automatic int idx_after(input int cur, input int n);
        return (cur == n - 1) ? 0 : cur + 1;
    endfunction

    // base + step folded into 0..n-1 by one conditional subtraction
    function automatic int idx_fold(input int base, input int step, input int n);
        int v;
        v = base + step;
        if (v >= n) v = v - n;
        return v;
    endfunction

endpackage

// File: rtl/rr_scan.sv
module rr_scan
    import stream_arb_pkg::*;
#(
    parameter int N  = 4,
    parameter int SW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [SW-1:0] base,
    output logic          found,
    output logic [SW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            int pos;
            pos = idx_fold(int'(base), i, N);
            if (!found && req[pos]) begin
                found = 1'b1;
                idx   = SW'(pos);
            end
        end
    end
endmodule

// File: rtl/grant_ctrl.sv
module grant_ctrl
    import stream_arb_pkg::*;
#(
    parameter int        N    = 4,
    parameter int        SW   = 2,
    parameter arb_mode_e MODE = ARB_PACKET
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          win_found,
    input  logic [SW-1:0] win_idx,
    input  logic [N-1:0]  src_valid,
    input  logic [N-1:0]  src_last,
    input  logic          out_ready,
    output logic [SW-1:0] ptr,
    output logic [SW-1:0] eff_sel,
    output logic          eff_valid
);
    logic [SW-1:0] sel_q;
    logic          locked_q;
    logic          hs;
    logic          unit_end;
    logic          unit_done;

    always_comb begin
        eff_sel   = locked_q ? sel_q : win_idx;
        eff_valid = locked_q ? src_valid[sel_q] : win_found;
        hs        = eff_valid && out_ready;
        unit_end  = (MODE == ARB_PACKET) ? src_last[eff_sel] : 1'b1;
        unit_done = hs && unit_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr      <= '0;
            sel_q    <= '0;
            locked_q <= 1'b0;
        end else if (eff_valid) begin
            if (!hs) begin
                sel_q    <= eff_sel;
                locked_q <= 1'b1;
            end else if (unit_end) begin
                locked_q <= 1'b0;
                ptr      <= SW'(idx_after(int'(eff_sel), N));
            end else begin
                sel_q    <= eff_sel;
                locked_q <= 1'b1;
            end
        end
    end

    AST_DONE_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
        unit_done |=> !locked_q);  // R5
    AST_STALL_LOCKS: assert property (@(posedge clk) disable iff (rst)
        (eff_valid && !out_ready) |=> (locked_q && sel_q == $past(eff_sel)));  // R3
    AST_PTR_FROM_WIN: assert property (@(posedge clk) disable iff (rst)
        unit_done |=> (ptr != $past(eff_sel)) || (N == 1));  // R6
endmodule

// File: rtl/strm_rr_merge.sv
module strm_rr_merge
    import stream_arb_pkg::*;
#(
    parameter int        SRC_COUNT = 4,
    parameter int        DATA_W    = 8,
    parameter arb_mode_e MODE      = ARB_PACKET
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [SRC_COUNT-1:0][DATA_W-1:0] src_data,
    input  logic [SRC_COUNT-1:0]             src_valid,
    input  logic [SRC_COUNT-1:0]             src_last,
    output logic [SRC_COUNT-1:0]             src_ready,
    output logic [DATA_W-1:0]                out_data,
    output logic                             out_valid,
    output logic                             out_last,
    input  logic                             out_ready
);
    localparam int SW = (SRC_COUNT > 1) ? $clog2(SRC_COUNT) : 1;

    logic [SW-1:0] ptr;
    logic          win_found;
    logic [SW-1:0] win_idx;
    logic [SW-1:0] eff_sel;
    logic          eff_valid;

    rr_scan #(.N(SRC_COUNT), .SW(SW)) u_scan (
        .req   (src_valid),
        .base  (ptr),
        .found (win_found),
        .idx   (win_idx)
    );

    grant_ctrl #(.N(SRC_COUNT), .SW(SW), .MODE(MODE)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .win_found (win_found),
        .win_idx   (win_idx),
        .src_valid (src_valid),
        .src_last  (src_last),
        .out_ready (out_ready),
        .ptr       (ptr),
        .eff_sel   (eff_sel),
        .eff_valid (eff_valid)
    );

    always_comb begin
        out_valid = eff_valid;
        out_data  = eff_valid ? src_data[eff_sel] : '0;
        out_last  = eff_valid ? src_last[eff_sel] : 1'b0;
        for (int i = 0; i < SRC_COUNT; i++) begin
            src_ready[i] = (eff_valid && (eff_sel == SW'(i))) ? out_ready : 1'b0;
        end
    end

    AST_ONE_READY: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_ready));  // R7
    AST_READY_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (src_ready != '0) |-> (out_ready && out_valid));  // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_data == '0 && !out_last && src_ready == '0));  // R9
    AST_STALL_STABLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));  // R3

    generate
        if (MODE == ARB_PACKET) begin : g_pkt_chk
            AST_PKT_STAYS: assert property (@(posedge clk) disable iff (rst)
                (out_valid && out_ready && !out_last) |=> (!out_valid || eff_sel == $past(eff_sel)));  // R4
        end
    endgenerate
endmodule

// File: tb/strm_rr_merge_test.sv
module strm_rr_merge_test;
    import stream_arb_pkg::*;

    localparam int N = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [N-1:0][7:0] tb_dat [2];
    logic [N-1:0]      tb_vld [2];
    logic [N-1:0]      tb_lst [2];
    logic [N-1:0]      tb_rdy [2];
    logic [7:0]        tb_odat [2];
    logic              tb_oval [2];
    logic              tb_olst [2];
    logic              tb_ordy [2];

    generate
        for (genvar k = 0; k < 2; k++) begin : g_mode
            strm_rr_merge #(
                .SRC_COUNT (N),
                .DATA_W    (8),
                .MODE      (k == 0 ? ARB_PACKET : ARB_BEAT)
            ) uut (
                .clk       (clk),
                .rst       (rst),
                .src_data  (tb_dat[k]),
                .src_valid (tb_vld[k]),
                .src_last  (tb_lst[k]),
                .src_ready (tb_rdy[k]),
                .out_data  (tb_odat[k]),
                .out_valid (tb_oval[k]),
                .out_last  (tb_olst[k]),
                .out_ready (tb_ordy[k])
            );
        end
    endgenerate

    int n_chk = 0;
    int n_bad = 0;

    // behavioural model state
    int mptr [2];
    int mown [2];
    int rem  [2][N];
    int seq  [2][N];
    int rxseq[2][N];
    bit acc  [2][N];
    int opkt [2];
    bit just_done[2];
    bit just_single[2];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input int pv, input int pr);
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < N; i++) begin
                if (acc[k][i]) begin
                    seq[k][i] = (seq[k][i] + 1) % 64;
                    rem[k][i] = rem[k][i] - 1;
                    acc[k][i] = 1'b0;
                    tb_vld[k][i] = 1'b0;
                end
                if (!tb_vld[k][i]) begin
                    if (int'($urandom % 100) < pv) begin
                        if (rem[k][i] == 0) rem[k][i] = 1 + int'($urandom % 4);
                        tb_vld[k][i] = 1'b1;
                        tb_dat[k][i] = {2'(i), 6'(seq[k][i])};
                        tb_lst[k][i] = (rem[k][i] == 1);
                    end else begin
                        tb_dat[k][i] = 8'h00;
                        tb_lst[k][i] = 1'b0;
                    end
                end
            end
            tb_ordy[k] = (int'($urandom % 100) < pr);
        end
    endtask

    task automatic compare_and_step(input bit first);
        for (int k = 0; k < 2; k++) begin
            int  s;
            bit  ev;
            bit  locked;
            int  edat;
            bit  elst;
            string vtag;
            s = 0; ev = 1'b0;
            locked = (mown[k] >= 0);
            if (locked) begin
                s = mown[k];
                ev = tb_vld[k][s];
            end else begin
                for (int j = 0; j < N; j++) begin
                    int p;
                    p = (mptr[k] + j) % N;
                    if (!ev && tb_vld[k][p]) begin ev = 1'b1; s = p; end
                end
            end
            edat = ev ? int'(tb_dat[k][s]) : 0;
            elst = ev ? tb_lst[k][s] : 1'b0;
            if (!ev) vtag = "R9";
            else if (locked) vtag = (k == 0) ? "R4" : "R3";
            else if (just_single[k]) vtag = "R5";
            else vtag = "R2";

            chk(tb_oval[k] == ev, vtag, int'(tb_oval[k]), int'(ev));
            chk(int'(tb_odat[k]) == edat, just_done[k] ? "R6" : (k == 1 ? "R8" : "R1"),
                int'(tb_odat[k]), edat);
            chk(tb_olst[k] == elst, (k == 0) ? "R4" : "R8", int'(tb_olst[k]), int'(elst));
            for (int i = 0; i < N; i++) begin
                bit er;
                er = ev && (i == s) && tb_ordy[k];
                chk(tb_rdy[k][i] == er, "R7", int'(tb_rdy[k][i]), int'(er));
            end
            if (first) begin
                chk(int'(tb_odat[k][7:6]) == 0, "R10", int'(tb_odat[k][7:6]), 0);
            end

            just_done[k]   = 1'b0;
            just_single[k] = 1'b0;
            if (ev && tb_ordy[k]) begin
                acc[k][s] = 1'b1;
                // R11: per-source order at the output
                chk(int'(tb_odat[k][5:0]) == rxseq[k][s], "R11", int'(tb_odat[k][5:0]), rxseq[k][s]);
                rxseq[k][s] = (rxseq[k][s] + 1) % 64;
                if (k == 0) begin
                    if (opkt[k] >= 0) chk(s == opkt[k], "R4", s, opkt[k]);
                    opkt[k] = tb_lst[k][s] ? -1 : s;
                end
                if (k == 1 || tb_lst[k][s]) begin
                    just_single[k] = (k == 0) && !locked;
                    just_done[k] = 1'b1;
                    mown[k] = -1;
                    mptr[k] = (s + 1) % N;
                end else begin
                    mown[k] = s;
                end
            end else if (ev) begin
                mown[k] = s;
            end
        end
    endtask

    task automatic run_phase(input int cycles, input int pv, input int pr);
        for (int c = 0; c < cycles; c++) begin
            @(posedge clk); #1;
            drive(pv, pr);
            @(negedge clk);
            compare_and_step(1'b0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        for (int k = 0; k < 2; k++) begin
            tb_dat[k] = '0; tb_vld[k] = '0; tb_lst[k] = '0; tb_ordy[k] = 1'b0;
            mptr[k] = 0; mown[k] = -1; opkt[k] = -1;
            just_done[k] = 1'b0; just_single[k] = 1'b0;
            for (int i = 0; i < N; i++) begin
                rem[k][i] = 0; seq[k][i] = 0; rxseq[k][i] = 0; acc[k][i] = 1'b0;
            end
        end
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // idle outputs under reset (R9, R10)
        for (int k = 0; k < 2; k++) begin
            chk(tb_oval[k] == 1'b0, "R10", int'(tb_oval[k]), 0);
            chk(tb_rdy[k] == '0, "R9", int'(tb_rdy[k]), 0);
        end
        @(posedge clk); #1;
        rst = 1'b0;
        drive(100, 0);
        @(negedge clk);
        compare_and_step(1'b1);   // R10: all valid after reset, source 0 first

        run_phase(400,  100, 100);  // all busy, no stalls
        run_phase(1500, 70,  60);   // stalls on both sides
        run_phase(1500, 20,  80);   // sparse sources
        run_phase(1500, 90,  25);   // heavy sink back-pressure
        run_phase(500,  100, 100);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule